// File: doc/BRIEF.md
# Polyphase Channeliser Front End with Delay-Indexed Coefficient Banks

This block sits in front of an M-point FFT in a uniform channelising filterbank. A stream of signed real samples comes in one at a time and is dealt round-robin onto M polyphase branches. Each branch keeps a short delay line of its own past samples. Once per block of M input samples, every branch computes a dot product of that delay line with its slice of a prototype lowpass filter. The M branch results leave together as one vector, ready for the transform stage.

The coefficients live in an internal ROM that holds sixteen banks. Each bank is the prototype filter resampled at a different sixteenth-of-a-sample offset. A 4-bit delay index chooses the bank for each block, so fractional-sample delay tracking needs no separate interpolator. All multiply-accumulate work runs at the output vector rate: each branch has one multiplier, and that multiplier steps through the taps while the input is held off. Results are rounded and saturated to the output width, and a sticky flag records any saturation.

Top module: `ppf_filter_front`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `ovf` is 0 and every branch delay line holds zeros.
- R2: Within a block, the n-th accepted sample (n = 0..M-1) goes to branch n. Branch 0 therefore takes the earliest sample of each block. Branch p appears on `out_data[p*OUT_W +: OUT_W]`.
- R3: Lane p of a vector equals the rounded and saturated value of the sum over t = 0..TAPS-1 of c(b,p,t)*x_p(t). Here x_p(0) is branch p's sample from the current block, x_p(t) is its sample from t blocks earlier, and samples from before reset count as 0.
- R4: Coefficient c(b,p,t) for bank b, branch p and tap t equals 64 + ((37*p + 101*t + 53*b) mod 256), treated as a signed COEF_W-bit value.
- R5: Bank b is the value of `dly_idx` in the cycle when the last sample (branch M-1) of the block is accepted. `dly_idx` has no effect in any other cycle.
- R6: Exactly one vector is produced for every M accepted samples. `in_ready` is 0 from the cycle after the last sample of a block is accepted until that block's vector is taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R8: Rounding adds 2^(SHIFT-1) to the full-precision sum and then shifts it arithmetically right by SHIFT bits. The result is clamped to the signed OUT_W range.
- R9: `ovf` becomes 1 when a vector with any clamped lane is presented. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | SAMP_W | Signed input sample |
| dly_idx | input | BANK_W | Fractional-delay bank index |
| out_valid | output | 1 | Branch vector is valid |
| out_ready | input | 1 | Downstream takes the vector |
| out_data | output | M*OUT_W | Signed branch results, branch p in lane p |
| ovf | output | 1 | Sticky saturation flag |

## Verification
Suppose a branch delay line is wrong, because a missed shift or a misrouted sample corrupted it. The error appears in that branch's lane on the very next vector, and it keeps reappearing for up to TAPS more vectors as the bad sample moves down the line. The bench therefore checks long runs of consecutive vectors, not single blocks. A wrong bank latch or tap counter corrupts every lane of the current vector at once. A commutator count that slips by one shifts samples across lanes, and the `in_ready` handshake loses block alignment at the next vector boundary. A flag that is not sticky is caught by clean vectors sent after a saturating run.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_MAC   = 2'd1,
        ST_ROUND = 2'd2,
        ST_SHOW  = 2'd3
    } ppf_state_e;

    // Coefficient generator for the constant ROM: bank, branch, tap.
    function automatic int ppf_coef(input int bank, input int branch, input int tap);
        return 64 + ((37 * branch + 101 * tap + 53 * bank) % 256);
    endfunction

endpackage

// File: rtl/ppf_coef_rom.sv
module ppf_coef_rom #(
    parameter int M      = 8,
    parameter int TAPS   = 16,
    parameter int COEF_W = 18,
    parameter int BANK_W = 4,
    localparam int TAP_W = $clog2(TAPS)
) (
    input  logic [BANK_W-1:0]   bank,
    input  logic [TAP_W-1:0]    tap,
    output logic [M*COEF_W-1:0] coefs
);
    for (genvar p = 0; p < M; p++) begin : g_lane
        always_comb begin
            coefs[p*COEF_W +: COEF_W] =
                COEF_W'(ppf_pkg::ppf_coef(int'(bank), p, int'(tap)));
        end
    end
endmodule

// File: rtl/ppf_commutator.sv
module ppf_commutator #(
    parameter int M      = 8,
    parameter int SAMP_W = 8,
    parameter int BANK_W = 4,
    localparam int CNT_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [SAMP_W-1:0]   sample,
    input  logic [BANK_W-1:0]   dly_idx,
    output logic                block_done,
    output logic [M*SAMP_W-1:0] block_vec,
    output logic [BANK_W-1:0]   bank
);
    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [M-1:0][SAMP_W-1:0]   stage;
        logic [BANK_W-1:0]          bank;
    } comm_t;

    comm_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        block_done = accept && (r_q.cnt == CNT_W'(M - 1));
        if (accept) begin
            r_d.stage[r_q.cnt] = sample;
            if (block_done) begin
                r_d.cnt  = '0;
                r_d.bank = dly_idx;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    // The last sample bypasses staging so all branches load in one edge.
    for (genvar p = 0; p < M; p++) begin : g_vec
        if (p == M - 1) begin : g_last
            assign block_vec[p*SAMP_W +: SAMP_W] = sample;
        end else begin : g_staged
            assign block_vec[p*SAMP_W +: SAMP_W] = r_q.stage[p];
        end
    end

    assign bank = r_q.bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ppf_branch.sv
module ppf_branch #(
    parameter int TAPS   = 16,
    parameter int SAMP_W = 8,
    parameter int COEF_W = 18,
    parameter int ACC_W  = 30,
    localparam int TAP_W = $clog2(TAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [SAMP_W-1:0]       new_sample,
    input  logic                    mac_en,
    input  logic [TAP_W-1:0]        tap,
    input  logic [COEF_W-1:0]       coef,
    output logic signed [ACC_W-1:0] acc
);
    typedef struct packed {
        logic [TAPS-1:0][SAMP_W-1:0] hist;
        logic signed [ACC_W-1:0]     acc;
    } br_t;

    br_t r_d, r_q;
    logic signed [SAMP_W+COEF_W-1:0] prod;

    always_comb begin
        prod = signed'(r_q.hist[tap]) * signed'(coef);
        r_d  = r_q;
        if (load) begin
            for (int t = TAPS - 1; t > 0; t--) begin
                r_d.hist[t] = r_q.hist[t-1];
            end
            r_d.hist[0] = new_sample;
            r_d.acc     = '0;
        end else if (mac_en) begin
            r_d.acc = r_q.acc + ACC_W'(prod);
        end
    end

    assign acc = r_q.acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ppf_round_sat.sv
module ppf_round_sat #(
    parameter int ACC_W = 30,
    parameter int OUT_W = 16,
    parameter int SHIFT = 3
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        value,
    output logic                    clamped
);
    localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W:0] MAXV   = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] MINV   = -MAXV - 1;

    logic signed [ACC_W:0] wide;
    logic signed [ACC_W:0] shifted;

    always_comb begin
        wide    = (ACC_W+1)'(acc) + HALF;
        shifted = wide >>> SHIFT;
        clamped = 1'b0;
        if (shifted > MAXV) begin
            value   = MAXV[OUT_W-1:0];
            clamped = 1'b1;
        end else if (shifted < MINV) begin
            value   = MINV[OUT_W-1:0];
            clamped = 1'b1;
        end else begin
            value   = shifted[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/ppf_filter_front.sv
module ppf_filter_front #(
    parameter int M      = 8,
    parameter int TAPS   = 16,
    parameter int SAMP_W = 8,
    parameter int COEF_W = 18,
    parameter int BANK_W = 4,
    parameter int OUT_W  = 16,
    parameter int SHIFT  = 3,
    localparam int TAP_W = $clog2(TAPS),
    localparam int ACC_W = SAMP_W + COEF_W + $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SAMP_W-1:0]    in_data,
    input  logic [BANK_W-1:0]    dly_idx,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [M*OUT_W-1:0]   out_data,
    output logic                 ovf
);
    import ppf_pkg::*;

    typedef struct packed {
        ppf_state_e          state;
        logic [TAP_W-1:0]    tap;
        logic [M*OUT_W-1:0]  data;
        logic                ovf;
    } top_t;

    top_t r_d, r_q;

    logic                accept;
    logic                block_done;
    logic [M*SAMP_W-1:0] block_vec;
    logic [BANK_W-1:0]   bank;
    logic [M*COEF_W-1:0] coefs;
    logic                mac_en;
    logic [M*OUT_W-1:0]  rounded;
    logic [M-1:0]        clamped;

    assign in_ready = (r_q.state == ST_FILL);
    assign accept   = in_valid && in_ready;
    assign mac_en   = (r_q.state == ST_MAC);

    ppf_commutator #(.M(M), .SAMP_W(SAMP_W), .BANK_W(BANK_W)) i_comm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sample     (in_data),
        .dly_idx    (dly_idx),
        .block_done (block_done),
        .block_vec  (block_vec),
        .bank       (bank)
    );

    ppf_coef_rom #(.M(M), .TAPS(TAPS), .COEF_W(COEF_W), .BANK_W(BANK_W)) i_rom (
        .bank  (bank),
        .tap   (r_q.tap),
        .coefs (coefs)
    );

    for (genvar p = 0; p < M; p++) begin : g_branch
        logic signed [ACC_W-1:0] acc;

        ppf_branch #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_br (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (block_done),
            .new_sample (block_vec[p*SAMP_W +: SAMP_W]),
            .mac_en     (mac_en),
            .tap        (r_q.tap),
            .coef       (coefs[p*COEF_W +: COEF_W]),
            .acc        (acc)
        );

        ppf_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_rs (
            .acc     (acc),
            .value   (rounded[p*OUT_W +: OUT_W]),
            .clamped (clamped[p])
        );
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_FILL: begin
                if (block_done) begin
                    r_d.state = ST_MAC;
                    r_d.tap   = '0;
                end
            end
            ST_MAC: begin
                if (r_q.tap == TAP_W'(TAPS - 1)) begin
                    r_d.state = ST_ROUND;
                end else begin
                    r_d.tap = r_q.tap + 1'b1;
                end
            end
            ST_ROUND: begin
                r_d.data  = rounded;
                r_d.ovf   = r_q.ovf | (|clamped);
                r_d.state = ST_SHOW;
            end
            ST_SHOW: begin
                if (out_ready) r_d.state = ST_FILL;
            end
            default: r_d.state = ST_FILL;
        endcase
    end

    assign out_valid = (r_q.state == ST_SHOW);
    assign out_data  = r_q.data;
    assign ovf       = r_q.ovf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_FILL, tap: '0, data: '0, ovf: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ppf_filter_front_chk.sv
module ppf_filter_front_chk #(
    parameter int M     = 8,
    parameter int OUT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [M*OUT_W-1:0] out_data,
    input logic               ovf
);
    int unsigned taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      taken_q <= 0;
        else if (out_valid && out_ready) taken_q <= 0;
        else if (in_valid && in_ready)   taken_q <= taken_q + 1;
    end

    a_r6_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r6_vector_per_block: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (taken_q == M));

    a_r6_no_excess_input: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (taken_q < M));

    a_r7_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

bind ppf_filter_front ppf_filter_front_chk #(.M(M), .OUT_W(OUT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .ovf       (ovf)
);

// File: tb/test_ppf_filter_front.sv
`timescale 1ns/1ps
module test_ppf_filter_front;
    localparam int M      = 8;
    localparam int TAPS   = 16;
    localparam int SAMP_W = 8;
    localparam int BANK_W = 4;
    localparam int OUT_W  = 16;
    localparam int SHIFT  = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [SAMP_W-1:0]   in_data = '0;
    logic [BANK_W-1:0]   dly_idx = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [M*OUT_W-1:0]  out_data;
    logic                ovf;

    int n_checks = 0;
    int n_fails  = 0;
    int hist[M][TAPS];
    int cur_bank = 0;
    int model_ovf = 0;

    always #4 clk = ~clk;

    ppf_filter_front #(.M(M), .TAPS(TAPS)) i_ppf_filter_front (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .dly_idx(dly_idx), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .ovf(ovf)
    );

    function automatic int coef(int b, int p, int t); // R4
        return 64 + ((37 * p + 101 * t + 53 * b) % 256);
    endfunction

    function automatic int expect_lane(int p, output bit sat); // R3, R8
        longint acc = 0;
        longint r;
        for (int t = 0; t < TAPS; t++) acc += longint'(coef(cur_bank, p, t)) * hist[p][t];
        r = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
        sat = 1'b0;
        if (r > 32767)  begin r = 32767;  sat = 1'b1; end
        if (r < -32768) begin r = -32768; sat = 1'b1; end
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_block(input int v[M], input int d[M]);
        for (int i = 0; i < M; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = SAMP_W'(v[i]);
            dly_idx  = BANK_W'(d[i]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R6 stall after block", int'(in_ready), 0);
        for (int p = 0; p < M; p++) begin
            for (int t = TAPS - 1; t > 0; t--) hist[p][t] = hist[p][t-1];
            hist[p][0] = v[p];
        end
        cur_bank = d[M-1]; // R5
    endtask

    task automatic take_vector(input string req, input int hold);
        int wait_n = 0;
        int bad = -1;
        int got = 0;
        int exp = 0;
        bit sat;
        logic [M*OUT_W-1:0] first;
        while (!out_valid && wait_n < 200) begin @(negedge clk); wait_n++; end
        check(out_valid == 1'b1, "R6 vector appears", int'(out_valid), 1);
        first = out_data;
        for (int h = 0; h < hold; h++) begin // R7
            @(negedge clk);
            check(out_valid && out_data == first && !in_ready, "R7 hold under backpressure",
                  int'(out_valid), 1);
        end
        for (int p = M - 1; p >= 0; p--) begin
            int e = expect_lane(p, sat);
            int g = int'(signed'(out_data[p*OUT_W +: OUT_W]));
            if (sat) model_ovf = 1;
            if (g != e) begin bad = p; got = g; exp = e; end
        end
        check(bad < 0, req, got, exp);
        check(ovf == model_ovf[0], "R9 sticky ovf", int'(ovf), model_ovf);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R6 vector consumed", int'(out_valid), 0);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(ovf == 1'b0, "R1 ovf", int'(ovf), 0);
    endtask

    task automatic t_impulse; // R2, R3, R4: single tap lights one lane
        int v[M];
        int d[M];
        for (int k = 0; k < M; k++) begin
            for (int i = 0; i < M; i++) begin v[i] = (i == k) ? 1 + k : 0; d[i] = 0; end
            send_block(v, d);
            take_vector("R2 commutator lane order", 0);
        end
    endtask

    task automatic t_ramp; // R3 over a full delay line
        int v[M];
        int d[M];
        for (int b = 0; b < TAPS + 2; b++) begin
            for (int i = 0; i < M; i++) begin v[i] = ((b * 7 + i * 13) % 61) - 30; d[i] = 3; end
            send_block(v, d);
            take_vector("R3 branch dot product", 0);
        end
    endtask

    task automatic t_bank; // R5
        int v[M];
        int d[M];
        for (int b = 0; b < 2 * BANK_W * 4; b++) begin
            for (int i = 0; i < M; i++) begin v[i] = 5 - i + b; d[i] = (b + i * 5) % 16; end
            d[M-1] = (b * 3) % 16;
            send_block(v, d);
            take_vector("R5 bank latched on last sample", 0);
        end
    endtask

    task automatic t_backpressure; // R6, R7
        int v[M];
        int d[M];
        for (int i = 0; i < M; i++) begin v[i] = -3 * i; d[i] = 9; end
        send_block(v, d);
        take_vector("R7 vector after stall", 6);
    endtask

    task automatic t_saturate; // R8, R9
        int v[M];
        int d[M];
        for (int b = 0; b < TAPS; b++) begin
            for (int i = 0; i < M; i++) begin v[i] = 127; d[i] = 15; end
            send_block(v, d);
            take_vector("R8 positive clamp", 0);
        end
        for (int b = 0; b < TAPS; b++) begin
            for (int i = 0; i < M; i++) begin v[i] = -128; d[i] = 0; end
            send_block(v, d);
            take_vector("R8 negative clamp", 0);
        end
        check(model_ovf == 1, "R9 saturation reached", model_ovf, 1);
        for (int b = 0; b < TAPS; b++) begin
            for (int i = 0; i < M; i++) begin v[i] = 0; d[i] = 1; end
            send_block(v, d);
            take_vector("R9 ovf stays after clean data", 0);
        end
    endtask

    initial begin
        for (int p = 0; p < M; p++) for (int t = 0; t < TAPS; t++) hist[p][t] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_impulse();
        t_ramp();
        t_bank();
        t_backpressure();
        t_saturate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule